// File: doc/BRIEF.md
# Selectable Reference Timing Divider

The block makes a reference timing signal out of one of two timing inputs: an on-board oscillator input or an externally supplied timing input. A static select picks the source. Both inputs are treated as asynchronous. Each one passes through a two-flop synchronizer into a single fast sampling clock. Every detected rising edge of the chosen source advances a 15-stage binary divider. The lowest four stages form a fast divide-by-16 section, and three cascaded counter sections of up to four bits carry the rest.

A 4-bit tap select picks what is driven out. It can pass the undivided source, or any division from 2 up to 32768 in powers of two. The chosen level is registered and driven as a true/complement pair. A polarity control flips the phase of the pair. In single-ended mode the complement is forced low. A retriggerable activity monitor watches the undivided chosen source and flags loss of timing when no rising edge arrives within a parameterised number of sampling-clock cycles.

Changes to the source select or the tap select act on the next sampling clock. They do not clear the divider, so the first output period after a switch may be short.

Top module: `reftime_divider`

## Requirements
- R1: `src_ext`=0 selects `osc_in` and `src_ext`=1 selects `ext_in`. Activity on the input that is not selected has no effect on `tim_p`, `tim_n` or `lost`.
- R2: With `tap_sel`=0, `tim_p` (at `invert`=0) equals the selected input's level as sampled three rising clock edges earlier: two synchronizer stages plus the output register.
- R3: The divider is a 15-bit count of detected rising edges of the selected source. A rising edge is seen one clock after it reaches the second synchronizer stage. The count wraps from 32767 to 0.
- R4: With `tap_sel`=k for k in 1..15, `tim_p` (at `invert`=0) takes bit k-1 of the count one clock after the count holds it. This gives division by 2^k.
- R5: `invert`=1 inverts `tim_p` relative to the `invert`=0 value. In the `invert`=0 setting the output is in phase with the selected tap.
- R6: With `balanced`=1, `tim_n` is the inverse of `tim_p` on every cycle after reset.
- R7: With `balanced`=0, `tim_n` is held at 0 and only `tim_p` toggles.
- R8: `lost` rises after TIMEOUT consecutive sampling clocks with no detected rising edge of the selected source. It falls on the clock that registers the next detected edge.
- R9: Synchronous reset clears the synchronizers, the divider and the activity count. It drives `tim_p`=0 and `tim_n`=0. It sets `lost`=1, which stays set until the first source edge is detected.
- R10: Changing `tap_sel` or `src_ext` affects the output on the next clock and leaves the divider count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_in | input | 1 | Internal oscillator timing input, asynchronous |
| ext_in | input | 1 | External timing input, asynchronous |
| src_ext | input | 1 | Source select: 0 internal, 1 external |
| tap_sel | input | 4 | 0 undivided, k selects divide by 2^k |
| invert | input | 1 | Polarity reversal of the output pair |
| balanced | input | 1 | 1 drives both outputs, 0 holds tim_n low |
| tim_p | output | 1 | True timing output |
| tim_n | output | 1 | Complement timing output |
| lost | output | 1 | Loss-of-timing-activity flag |

## Verification
The hardest state to reach from the ports is the wrap of the top divider stage. It only appears after 32768 detected source edges, and each edge needs at least two sampling clocks. A long directed run toggles the internal source on every clock with the top tap selected, which takes the count through a full wrap. Random stretches change source, tap, polarity and balance mid-run to cover the unreset switch-over. A silent phase toggles only the unselected input, so the activity timeout expires while decoy edges are present.

// File: rtl/reftime_pkg.sv
package reftime_pkg;
  typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} src_e;

  // number of cascaded sections needed for the slow part of the divider
  function automatic int slow_sections(input int stages, input int fast_w, input int sec_w);
    return (stages - fast_w + sec_w - 1) / sec_w;
  endfunction

  // width of slow section idx (last one may be narrower)
  function automatic int section_width(input int stages, input int fast_w,
                                       input int sec_w, input int idx);
    int rem;
    rem = stages - fast_w - idx * sec_w;
    return (rem < sec_w) ? rem : sec_w;
  endfunction
endpackage

// File: rtl/rt_sync2.sv
module rt_sync2 (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync
);
  logic stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= 1'b0;
      d_sync <= 1'b0;
    end else begin
      stage1 <= d_async;
      d_sync <= stage1;
    end
  end
endmodule

// File: rtl/rt_count_sect.sv
module rt_count_sect #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= q + W'(1);
  end
endmodule

// File: rtl/rt_tap_div.sv
module rt_tap_div #(
  parameter int STAGES = 15,
  parameter int FAST_W = 4,
  parameter int SEC_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  output logic [STAGES-1:0] cnt
);
  import reftime_pkg::*;
  localparam int NSEC = slow_sections(STAGES, FAST_W, SEC_W);

  logic [NSEC-1:0] carry;

  // fast divide-by-2^FAST_W front section
  rt_count_sect #(.W(FAST_W)) u_fast (
    .clk(clk), .rst(rst), .en(step), .q(cnt[FAST_W-1:0])
  );

  assign carry[0] = step & (&cnt[FAST_W-1:0]);

  for (genvar i = 0; i < NSEC; i++) begin : g_slow
    localparam int LO = FAST_W + i * SEC_W;
    localparam int SW = section_width(STAGES, FAST_W, SEC_W, i);

    rt_count_sect #(.W(SW)) u_sect (
      .clk(clk), .rst(rst), .en(carry[i]), .q(cnt[LO +: SW])
    );

    if (i < NSEC - 1) begin : g_carry
      assign carry[i+1] = carry[i] & (&cnt[LO +: SW]);
    end
  end
endmodule

// File: rtl/rt_activity_mon.sv
module rt_activity_mon #(
  parameter int TIMEOUT = 1000,
  localparam int AW = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          retrig,
  output logic [AW-1:0] idle_cnt,
  output logic          lost
);
  localparam logic [AW-1:0] LIMIT = AW'(TIMEOUT);

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt <= '0;
      lost     <= 1'b1;
    end else if (retrig) begin
      idle_cnt <= '0;
      lost     <= 1'b0;
    end else if (idle_cnt != LIMIT) begin
      idle_cnt <= idle_cnt + AW'(1);
      if (idle_cnt + AW'(1) == LIMIT) lost <= 1'b1;
    end
  end
endmodule

// File: rtl/reftime_divider.sv
module reftime_divider #(
  parameter int STAGES  = 15,
  parameter int FAST_W  = 4,
  parameter int SEC_W   = 4,
  parameter int TIMEOUT = 1000,
  localparam int TAP_W  = $clog2(STAGES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_in,
  input  logic             ext_in,
  input  logic             src_ext,
  input  logic [TAP_W-1:0] tap_sel,
  input  logic             invert,
  input  logic             balanced,
  output logic             tim_p,
  output logic             tim_n,
  output logic             lost
);
  import reftime_pkg::*;
  localparam int AW = $clog2(TIMEOUT + 1);

  // pick the undivided level or one divider stage
  function automatic logic tap_level(input logic [STAGES-1:0] c, input logic lvl,
                                     input logic [TAP_W-1:0] sel);
    if (sel == '0) return lvl;
    return c[sel - TAP_W'(1)];
  endfunction

  logic osc_s, ext_s;
  logic src_lvl, src_lvl_d;
  logic src_rise;
  logic [STAGES-1:0] div_cnt;
  logic [AW-1:0] act_cnt;
  logic out_lvl;

  rt_sync2 u_sync_osc (.clk(clk), .rst(rst), .d_async(osc_in), .d_sync(osc_s));
  rt_sync2 u_sync_ext (.clk(clk), .rst(rst), .d_async(ext_in), .d_sync(ext_s));

  assign src_lvl  = (src_e'(src_ext) == SRC_EXT) ? ext_s : osc_s;
  assign src_rise = src_lvl & ~src_lvl_d;

  always_ff @(posedge clk) begin
    if (rst) src_lvl_d <= 1'b0;
    else     src_lvl_d <= src_lvl;
  end

  rt_tap_div #(.STAGES(STAGES), .FAST_W(FAST_W), .SEC_W(SEC_W)) u_div (
    .clk(clk), .rst(rst), .step(src_rise), .cnt(div_cnt)
  );

  rt_activity_mon #(.TIMEOUT(TIMEOUT)) u_act (
    .clk(clk), .rst(rst), .retrig(src_rise), .idle_cnt(act_cnt), .lost(lost)
  );

  assign out_lvl = tap_level(div_cnt, src_lvl, tap_sel) ^ invert;

  always_ff @(posedge clk) begin
    if (rst) begin
      tim_p <= 1'b0;
      tim_n <= 1'b0;
    end else begin
      tim_p <= out_lvl;
      tim_n <= balanced ? ~out_lvl : 1'b0;
    end
  end
endmodule

// File: rtl/reftime_divider_chk.sv
module reftime_divider_chk #(
  parameter int STAGES  = 15,
  parameter int TIMEOUT = 1000,
  parameter int TAP_W   = 4,
  parameter int AW      = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              src_rise,
  input logic [STAGES-1:0] div_cnt,
  input logic [AW-1:0]     act_cnt,
  input logic [TAP_W-1:0]  tap_sel,
  input logic              invert,
  input logic              balanced,
  input logic              tim_p,
  input logic              tim_n,
  input logic              lost
);
  AST_DIV_STEP: assert property (@(posedge clk) disable iff (rst)
    src_rise |=> div_cnt == $past(div_cnt) + STAGES'(1)); // R3
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
    !src_rise |=> $stable(div_cnt)); // R10
  AST_TAP_BIT: assert property (@(posedge clk) disable iff (rst)
    (tap_sel != '0) |=> tim_p == ($past(div_cnt[tap_sel - TAP_W'(1)]) ^ $past(invert))); // R4
  AST_BAL_PAIR: assert property (@(posedge clk) disable iff (rst)
    balanced |=> tim_n == !tim_p); // R6
  AST_UNBAL_LOW: assert property (@(posedge clk) disable iff (rst)
    !balanced |=> !tim_n); // R7
  AST_LOST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    src_rise |=> !lost); // R8
  AST_LOST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (lost && !src_rise) |=> lost); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    act_cnt <= AW'(TIMEOUT)); // R8
endmodule

bind reftime_divider reftime_divider_chk #(
  .STAGES(STAGES), .TIMEOUT(TIMEOUT), .TAP_W(TAP_W), .AW(AW)
) u_chk (
  .clk(clk), .rst(rst), .src_rise(src_rise), .div_cnt(div_cnt), .act_cnt(act_cnt),
  .tap_sel(tap_sel), .invert(invert), .balanced(balanced),
  .tim_p(tim_p), .tim_n(tim_n), .lost(lost)
);

// File: tb/tb_reftime_divider.sv
module tb_reftime_divider;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_in = 1'b0, ext_in = 1'b0, src_ext = 1'b0;
  logic [3:0] tap_sel = 4'd0;
  logic invert = 1'b0, balanced = 1'b1;
  logic tim_p, tim_n, lost;

  int checks = 0, failures = 0;
  string tag = "R9";

  // reference model state
  bit m_o1, m_o2, m_e1, m_e2, m_prev, m_tp, m_tn, m_lost;
  int m_edges, m_gap;

  always #(CLK_PERIOD/2) clk = ~clk;

  reftime_divider #(.TIMEOUT(TO)) dut (
    .clk(clk), .rst(rst), .osc_in(osc_in), .ext_in(ext_in), .src_ext(src_ext),
    .tap_sel(tap_sel), .invert(invert), .balanced(balanced),
    .tim_p(tim_p), .tim_n(tim_n), .lost(lost)
  );

  // expected pre-polarity output for a tap setting: level, or bit k-1 of the edge count
  function automatic bit want_tap(int edges, bit lvl, int tap);
    if (tap == 0) return lvl;
    return bit'((edges / (1 << (tap - 1))) % 2);
  endfunction

  task automatic check(string req, bit act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // advance the model over the posedge that just passed, using the held inputs
  task automatic model_edge();
    bit lvl, pre;
    if (rst) begin
      {m_o1, m_o2, m_e1, m_e2, m_prev, m_tp, m_tn} = '0;
      m_lost = 1'b1; m_edges = 0; m_gap = 0;
    end else begin
      lvl = src_ext ? m_e2 : m_o2;
      pre = want_tap(m_edges, lvl, int'(tap_sel));
      m_tp = pre ^ invert;
      m_tn = balanced ? !m_tp : 1'b0;
      if (lvl && !m_prev) begin
        m_edges = (m_edges + 1) % 32768; m_gap = 0; m_lost = 1'b0;
      end else begin
        if (m_gap < TO) m_gap++;
        if (m_gap == TO) m_lost = 1'b1;
      end
      m_prev = lvl;
      m_o2 = m_o1; m_o1 = osc_in;
      m_e2 = m_e1; m_e1 = ext_in;
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    model_edge();
    check(tag, tim_p, m_tp, "tim_p");
    check(balanced ? "R6" : "R7", tim_n, m_tn, "tim_n");
    check((tag == "R1" || tag == "R9") ? tag : "R8", lost, m_lost, "lost");
  endtask

  task automatic rand_cfg();
    tap_sel  = 4'($urandom_range(0, 15));
    invert   = 1'($urandom_range(0, 1));
    balanced = 1'($urandom_range(0, 1));
  endtask

  initial begin
    void'($urandom(32'd5150));
    // R9: reset state
    repeat (3) cycle();
    check("R9", tim_p, 1'b0, "reset tim_p");
    check("R9", tim_n, 1'b0, "reset tim_n");
    check("R9", lost, 1'b1, "reset lost");
    rst = 1'b0;
    tag = "R9";
    repeat (10) cycle();
    check("R9", lost, 1'b1, "lost held before first edge");

    // R2: undivided tap, internal source, normal polarity
    tag = "R2"; tap_sel = 0; invert = 0; balanced = 1;
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 2) == 0) osc_in = ~osc_in;
      cycle();
    end

    // R4 / R5: random taps and polarity, both sources, settings change mid-run (R10)
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 199) == 0) rand_cfg();
      if ($urandom_range(0, 399) == 0) src_ext = ~src_ext;
      tag = (invert) ? "R5" : ((tap_sel == 0) ? "R2" : "R10");
      if ($urandom_range(0, 2) == 0) osc_in = ~osc_in;
      if ($urandom_range(0, 3) == 0) ext_in = ~ext_in;
      cycle();
    end

    // R1: selected internal source silent, external toggling
    tag = "R1"; src_ext = 0; tap_sel = 0; invert = 0; balanced = 0;
    for (int i = 0; i < 3 * TO; i++) begin
      ext_in = ~ext_in;
      cycle();
    end
    check("R1", lost, 1'b1, "lost with only unselected input active");
    check("R7", tim_n, 1'b0, "tim_n low in unbalanced mode");

    // R8: single edge clears, then silence sets again
    tag = "R8"; osc_in = ~osc_in;
    repeat (2) cycle();
    if (osc_in == 1'b0) begin osc_in = 1'b1; repeat (2) cycle(); end
    repeat (4) cycle();
    check("R8", lost, 1'b0, "lost cleared after edge");
    repeat (TO + 4) cycle();
    check("R8", lost, 1'b1, "lost set after timeout");

    // R3: full wrap of the top stage, internal source toggling each clock
    tag = "R3"; src_ext = 0; tap_sel = 15; invert = 0; balanced = 1;
    for (int i = 0; i < 2 * 32768 + 2 * 1500; i++) begin
      osc_in = ~osc_in;
      cycle();
    end
    rst = 1'b1;
    tag = "R9";
    repeat (2) cycle();
    check("R9", tim_p, 1'b0, "reset after run tim_p");
    check("R9", lost, 1'b1, "reset after run lost");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule